// File: doc/BRIEF.md
# DAC Output Protect Sequencer

This block drives a bank of DAC channel codes and their high-impedance power-down controls to a known safe state when a fault is raised, with no processor involvement. A fault can come from an asynchronous input pin or from a software trigger bit. A two-bit behaviour select picks one of four responses:

- an immediate switch to high impedance;
- a direct jump to the codes held in nonvolatile storage;
- a paced slew toward the low margin codes;
- a paced slew toward the high margin codes.

Every response ends with all channels powered down.

While a response runs, the block raises a write-inhibit toward the host side. Host writes and the boot load are dropped during that time. A sticky status flag records that a response took place, and a status read clears it only once the response is over.

After reset every channel sits in power-down. A boot load can then bring all channels up at their preprogrammed codes. A host write sets the code and power-down bit of one channel.

Top module: `dac_safe_state_ctrl`

## Requirements
- R1: After reset every channel code is 0, every power-down bit is 1, and `wr_inhibit`, `prot_flag` and `prot_done` are 0.
- R2: With no response running and no trigger in the cycle, a `boot_load` pulse loads every channel with its stored code from `nvm_code` and clears every power-down bit at the next edge.
- R3: A response starts either on a `sw_trigger` cycle, or on a rising edge of `fault_pin`, which passes through a two-flop synchroniser so that the response starts on the third clock edge after the pin rises. A pin that stays high does not start a second response.
- R4: With `mode_sel` = 2'b00, every power-down bit goes to 1 at the first edge after the starting edge, and the codes are left unchanged.
- R5: With `mode_sel` = 2'b01, every channel takes its `nvm_code` value at the starting edge and holds it for one further cycle. Power-down is asserted at the second edge after the start.
- R6: With `mode_sel` = 2'b10 (toward `margin_lo`) or 2'b11 (toward `margin_hi`), each code moves by `slew_step` every `slew_period` cycles, where 0 counts as 1 for both. The code clamps exactly at the target from above or below. Power-down is asserted two edges after the last channel reaches its target.
- R7: `wr_inhibit` is high from the starting edge until the response completes. Host writes and boot loads presented while it is high, or in the same cycle as an accepted trigger, have no effect.
- R8: Triggers that arrive while a response is running are ignored and do not change its timing.
- R9: `prot_done` is a single-cycle pulse, high on the cycle in which all power-down bits have just been set.
- R10: `prot_flag` is set at the starting edge. A `status_rd` pulse while a response runs leaves it set, and a `status_rd` pulse with no response running clears it at the next edge. A trigger wins over a read in the same cycle.
- R11: With no response running, a `wr_valid` pulse sets the code of channel `wr_chan` to `wr_code` and its power-down bit to `wr_pd`. Channel i occupies bits [i*CODE_W +: CODE_W] of every code bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_pin | input | 1 | Asynchronous fault input, rising edge triggers |
| sw_trigger | input | 1 | Software trigger bit, one-cycle pulse |
| mode_sel | input | 2 | Response select |
| slew_step | input | STEP_W | Code change per slew step |
| slew_period | input | DIV_W | Cycles between slew steps |
| nvm_code | input | NUM_CH*CODE_W | Stored per-channel codes |
| margin_lo | input | NUM_CH*CODE_W | Per-channel low margin codes |
| margin_hi | input | NUM_CH*CODE_W | Per-channel high margin codes |
| boot_load | input | 1 | Load stored codes and power up all channels |
| wr_valid | input | 1 | Host write strobe |
| wr_chan | input | CH_IDX_W | Host write channel index |
| wr_code | input | CODE_W | Host write code |
| wr_pd | input | 1 | Host write power-down value |
| status_rd | input | 1 | Status register read strobe |
| dac_code | output | NUM_CH*CODE_W | Per-channel output codes |
| dac_pd | output | NUM_CH | Per-channel power-down (high impedance) |
| wr_inhibit | output | 1 | Host write lockout |
| prot_flag | output | 1 | Sticky response status flag |
| prot_done | output | 1 | Completion pulse |

## Verification
Three events can land in the same cycle as a trigger: a host write or boot load, a status read, and a second trigger while a response is running. The bench places a write and a read exactly on the trigger cycle. It expects the write to be lost and the flag to stay set. During random responses it injects writes, boot loads, reads and repeat triggers on random cycles. Each response is judged by checking the codes every cycle against a computed slew profile and by comparing the completion cycle with the predicted count.

// File: rtl/dac_prot_pkg.sv
// Package: shared encodings for the DAC protect sequencer.
package dac_prot_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HOLD   = 2'd1,
        SEQ_SLEW   = 2'd2,
        SEQ_FINISH = 2'd3
    } seq_state_e;

    // Response select values; bit 0 also picks the slew target (1 = high margin).
    localparam logic [1:0] PM_HIZ = 2'b00;
    localparam logic [1:0] PM_NVM = 2'b01;
    localparam logic [1:0] PM_MLO = 2'b10;
    localparam logic [1:0] PM_MHI = 2'b11;

endpackage

// File: rtl/dac_prot_sync.sv
// Module: dac_prot_sync
// Brings the asynchronous fault pin into the clock domain through two flops
// and produces a one-cycle pulse on its rising edge.
// Assumes: pin pulses last longer than two clock periods.
module dac_prot_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_rise
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pin_rise = sync_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);  // R3
endmodule

// File: rtl/dac_prot_seq.sv
// Module: dac_prot_seq
// Control state machine for the protect response: accepts a trigger when idle,
// runs the selected response, paces slew steps and flags completion.
// Assumes: mode_sel and slew_period are stable while a response runs.
module dac_prot_seq
    import dac_prot_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_req,
    input  logic [1:0]       mode_sel,
    input  logic [DIV_W-1:0] slew_period,
    input  logic             all_at_target,
    output logic             busy,
    output logic             trig_accept,
    output logic             load_nvm,
    output logic             slew_tick,
    output logic             tgt_hi,
    output logic             pd_all,
    output logic             done
);
    seq_state_e       state_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] period_eff;
    logic             period_last;

    assign busy        = (state_q != SEQ_IDLE);
    assign trig_accept = trig_req && !busy;
    assign load_nvm    = trig_accept && (mode_sel == PM_NVM);
    assign period_eff  = (slew_period == '0) ? DIV_W'(1) : slew_period;
    assign period_last = (cnt_q >= period_eff - DIV_W'(1));
    assign slew_tick   = (state_q == SEQ_SLEW) && !all_at_target && period_last;
    assign pd_all      = (state_q == SEQ_FINISH);

    // State, pace counter, target select and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            tgt_hi  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (trig_accept) begin
                        cnt_q  <= '0;
                        tgt_hi <= mode_sel[0];
                        case (mode_sel)
                            PM_HIZ:  state_q <= SEQ_FINISH;
                            PM_NVM:  state_q <= SEQ_HOLD;
                            default: state_q <= SEQ_SLEW;
                        endcase
                    end
                end
                SEQ_HOLD: state_q <= SEQ_FINISH;
                SEQ_SLEW: begin
                    if (all_at_target) begin
                        state_q <= SEQ_FINISH;
                    end else if (period_last) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    done    <= 1'b1;
                end
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        trig_accept |=> busy);  // R7
    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD) |=> (state_q == SEQ_FINISH));  // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R7
endmodule

// File: rtl/dac_prot_chan.sv
// Module: dac_prot_chan
// One DAC channel: holds its code and power-down bit, applies loads and
// moves the code one clamped step toward its target on each slew tick.
// Assumes: a load and a slew tick never need to act together (load wins).
module dac_prot_chan #(
    parameter int CODE_W = 12,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_load,
    input  logic [CODE_W-1:0] code_val,
    input  logic              pd_load,
    input  logic              pd_val,
    input  logic              pd_force,
    input  logic              slew_tick,
    input  logic [CODE_W-1:0] target,
    input  logic [STEP_W-1:0] step,
    output logic [CODE_W-1:0] code,
    output logic              pd,
    output logic              at_target
);
    localparam int WIDE_W = (CODE_W > STEP_W) ? CODE_W + 1 : STEP_W + 1;

    logic [WIDE_W-1:0] step_w;
    logic [WIDE_W-1:0] code_w;
    logic [WIDE_W-1:0] tgt_w;
    logic [CODE_W-1:0] slew_next;

    assign step_w    = (step == '0) ? WIDE_W'(1) : WIDE_W'(step);
    assign code_w    = WIDE_W'(code);
    assign tgt_w     = WIDE_W'(target);
    assign at_target = (code == target);

    // One clamped step toward the target in either direction.
    always_comb begin
        if (code_w < tgt_w) begin
            slew_next = (tgt_w - code_w <= step_w) ? target : CODE_W'(code_w + step_w);
        end else if (code_w > tgt_w) begin
            slew_next = (code_w - tgt_w <= step_w) ? target : CODE_W'(code_w - step_w);
        end else begin
            slew_next = code;
        end
    end

    // Code register: load first, then slew.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (code_load) begin
            code <= code_val;
        end else if (slew_tick) begin
            code <= slew_next;
        end
    end

    // Power-down register: forced on at the end of a response, else loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd <= 1'b1;
        end else if (pd_force) begin
            pd <= 1'b1;
        end else if (pd_load) begin
            pd <= pd_val;
        end
    end

    AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (slew_tick && !code_load && code <= target) |=> (code <= $past(target)));  // R6
    AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (slew_tick && !code_load && code >= target) |=> (code >= $past(target)));  // R6
    AST_FORCE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        pd_force |=> pd);  // R9
endmodule

// File: rtl/dac_safe_state_ctrl.sv
// Module: dac_safe_state_ctrl
// Top of the protect sequencer: synchronises the fault pin, runs the response
// state machine, gates host writes and boot loads, keeps the sticky flag and
// instantiates one register slice per channel.
// Assumes: stored and margin codes are stable while a response runs.
module dac_safe_state_ctrl
    import dac_prot_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int STEP_W = 8,
    parameter int DIV_W  = 8,
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BUS_W    = NUM_CH * CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault_pin,
    input  logic                sw_trigger,
    input  logic [1:0]          mode_sel,
    input  logic [STEP_W-1:0]   slew_step,
    input  logic [DIV_W-1:0]    slew_period,
    input  logic [BUS_W-1:0]    nvm_code,
    input  logic [BUS_W-1:0]    margin_lo,
    input  logic [BUS_W-1:0]    margin_hi,
    input  logic                boot_load,
    input  logic                wr_valid,
    input  logic [CH_IDX_W-1:0] wr_chan,
    input  logic [CODE_W-1:0]   wr_code,
    input  logic                wr_pd,
    input  logic                status_rd,
    output logic [BUS_W-1:0]    dac_code,
    output logic [NUM_CH-1:0]   dac_pd,
    output logic                wr_inhibit,
    output logic                prot_flag,
    output logic                prot_done
);
    logic              pin_rise;
    logic              trig_req;
    logic              busy;
    logic              trig_accept;
    logic              load_nvm;
    logic              slew_tick;
    logic              tgt_hi;
    logic              pd_all;
    logic              host_open;
    logic              boot_acc;
    logic              wr_acc;
    logic [NUM_CH-1:0] at_vec;

    dac_prot_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (fault_pin),
        .pin_rise  (pin_rise)
    );

    assign trig_req = pin_rise | sw_trigger;

    dac_prot_seq #(.DIV_W(DIV_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_req      (trig_req),
        .mode_sel      (mode_sel),
        .slew_period   (slew_period),
        .all_at_target (&at_vec),
        .busy          (busy),
        .trig_accept   (trig_accept),
        .load_nvm      (load_nvm),
        .slew_tick     (slew_tick),
        .tgt_hi        (tgt_hi),
        .pd_all        (pd_all),
        .done          (prot_done)
    );

    // Host-side commands pass only with no response running and no trigger now.
    assign host_open  = !busy && !trig_req;
    assign boot_acc   = boot_load && host_open;
    assign wr_acc     = wr_valid && host_open && !boot_load;
    assign wr_inhibit = busy;

    // Sticky flag: set by an accepted trigger, cleared by a read once idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_flag <= 1'b0;
        end else if (trig_accept) begin
            prot_flag <= 1'b1;
        end else if (status_rd && !busy) begin
            prot_flag <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_hit;
        assign wr_hit = wr_acc && (wr_chan == CH_IDX_W'(i));

        dac_prot_chan #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .code_load (load_nvm || boot_acc || wr_hit),
            .code_val  ((load_nvm || boot_acc) ? nvm_code[i*CODE_W +: CODE_W] : wr_code),
            .pd_load   (boot_acc || wr_hit),
            .pd_val    (boot_acc ? 1'b0 : wr_pd),
            .pd_force  (pd_all),
            .slew_tick (slew_tick),
            .target    (tgt_hi ? margin_hi[i*CODE_W +: CODE_W] : margin_lo[i*CODE_W +: CODE_W]),
            .step      (slew_step),
            .code      (dac_code[i*CODE_W +: CODE_W]),
            .pd        (dac_pd[i]),
            .at_target (at_vec[i])
        );
    end

    AST_RESET_HIZ: assert property (@(posedge clk)
        $past(!rst_n) |-> (&dac_pd && !prot_flag && !wr_inhibit));  // R1
    AST_FLAG_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_accept |=> prot_flag);  // R10
    AST_FLAG_KEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && prot_flag) |=> prot_flag);  // R10
    AST_DONE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        prot_done |-> &dac_pd);  // R9
    AST_BUSY_NO_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pd_all) |=> $stable(dac_pd));  // R7
endmodule

// File: tb/dac_safe_state_ctrl_tb.sv
module dac_safe_state_ctrl_tb;
    localparam int NUM_CH = 4;
    localparam int CODE_W = 12;
    localparam int STEP_W = 8;
    localparam int DIV_W  = 8;
    localparam int CH_IDX_W = 2;
    localparam int BUS_W = NUM_CH * CODE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_pin = 1'b0;
    logic sw_trigger = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [STEP_W-1:0] slew_step = 8'd1;
    logic [DIV_W-1:0] slew_period = 8'd1;
    logic [BUS_W-1:0] nvm_code = '0;
    logic [BUS_W-1:0] margin_lo = '0;
    logic [BUS_W-1:0] margin_hi = '0;
    logic boot_load = 1'b0;
    logic wr_valid = 1'b0;
    logic [CH_IDX_W-1:0] wr_chan = '0;
    logic [CODE_W-1:0] wr_code = '0;
    logic wr_pd = 1'b0;
    logic status_rd = 1'b0;
    logic [BUS_W-1:0] dac_code;
    logic [NUM_CH-1:0] dac_pd;
    logic wr_inhibit;
    logic prot_flag;
    logic prot_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_code [NUM_CH];
    logic exp_pd [NUM_CH];

    always #5 clk = ~clk;

    dac_safe_state_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .sw_trigger(sw_trigger),
        .mode_sel(mode_sel), .slew_step(slew_step), .slew_period(slew_period),
        .nvm_code(nvm_code), .margin_lo(margin_lo), .margin_hi(margin_hi),
        .boot_load(boot_load), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_code(wr_code), .wr_pd(wr_pd), .status_rd(status_rd),
        .dac_code(dac_code), .dac_pd(dac_pd), .wr_inhibit(wr_inhibit),
        .prot_flag(prot_flag), .prot_done(prot_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int code_of(input int i);
        return int'(dac_code[i*CODE_W +: CODE_W]);
    endfunction

    function automatic int fld(input logic [BUS_W-1:0] bus, input int i);
        return int'(bus[i*CODE_W +: CODE_W]);
    endfunction

    // Code after a number of clamped slew steps (R6).
    function automatic int slew_at(input int s, input int t, input int st, input int n);
        if (s < t) return (t - s <= st * n) ? t : s + st * n;
        if (s > t) return (s - t <= st * n) ? t : s - st * n;
        return s;
    endfunction

    function automatic int steps_needed(input int s, input int t, input int st);
        int d;
        d = (s > t) ? s - t : t - s;
        return (d + st - 1) / st;
    endfunction

    // Global watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic randomize_codes();
        for (int i = 0; i < NUM_CH; i++) begin
            nvm_code[i*CODE_W +: CODE_W]  = CODE_W'($urandom);
            margin_lo[i*CODE_W +: CODE_W] = CODE_W'($urandom);
            margin_hi[i*CODE_W +: CODE_W] = CODE_W'($urandom);
        end
    endtask

    task automatic do_boot();
        boot_load = 1'b1;
        @(negedge clk);
        boot_load = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            exp_code[i] = fld(nvm_code, i);
            exp_pd[i] = 1'b0;
            chk(code_of(i) == exp_code[i], "R2 boot code", code_of(i), exp_code[i]);
            chk(dac_pd[i] == 1'b0, "R2 boot pd", int'(dac_pd[i]), 0);
        end
    endtask

    task automatic host_write(input int ch, input int code, input logic pd);
        wr_valid = 1'b1; wr_chan = CH_IDX_W'(ch); wr_code = CODE_W'(code); wr_pd = pd;
        @(negedge clk);
        wr_valid = 1'b0;
        exp_code[ch] = code; exp_pd[ch] = pd;
        chk(code_of(ch) == code, "R11 write code", code_of(ch), code);
        chk(dac_pd[ch] == pd, "R11 write pd", int'(dac_pd[ch]), int'(pd));
    endtask

    task automatic clear_flag();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk(prot_flag == 1'b0, "R10 read clears", int'(prot_flag), 0);
    endtask

    // Runs one response and checks it cycle by cycle.
    task automatic run_protect(input logic [1:0] mode, input bit use_pin, input bit noise);
        int p_eff, st_eff, nmax, pred, k, e;
        int start [NUM_CH];
        int tgt [NUM_CH];
        string tag;
        bit rd_issued;
        mode_sel = mode;
        p_eff = (slew_period == 0) ? 1 : int'(slew_period);
        st_eff = (slew_step == 0) ? 1 : int'(slew_step);
        tag = (mode == 2'b00) ? "R4" : (mode == 2'b01) ? "R5" : "R6";
        nmax = 0;
        for (int i = 0; i < NUM_CH; i++) begin
            start[i] = exp_code[i];
            tgt[i] = mode[0] ? fld(margin_hi, i) : fld(margin_lo, i);
            if (steps_needed(start[i], tgt[i], st_eff) > nmax) nmax = steps_needed(start[i], tgt[i], st_eff);
        end
        pred = (mode == 2'b00) ? 1 : (mode == 2'b01) ? 2 : nmax * p_eff + 2;
        if (use_pin) begin
            fault_pin = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk(wr_inhibit == 1'b0, "R3 pin sync delay", int'(wr_inhibit), 0);
            @(negedge clk);
        end else begin
            sw_trigger = 1'b1;
            @(negedge clk);
            sw_trigger = 1'b0;
        end
        chk(prot_flag == 1'b1, "R10 flag set", int'(prot_flag), 1);
        k = 0;
        while (!prot_done && k < 6000) begin
            chk(wr_inhibit == 1'b1, "R7 inhibit high", int'(wr_inhibit), 1);
            for (int i = 0; i < NUM_CH; i++) begin
                e = (mode == 2'b00) ? start[i] : (mode == 2'b01) ? fld(nvm_code, i)
                    : slew_at(start[i], tgt[i], st_eff, k / p_eff);
                chk(code_of(i) == e, {tag, " code in flight"}, code_of(i), e);
            end
            rd_issued = 1'b0;
            if (noise) begin
                case ($urandom % 5)
                    0: sw_trigger = 1'b1;
                    1: begin wr_valid = 1'b1; wr_chan = CH_IDX_W'($urandom); wr_code = CODE_W'($urandom); wr_pd = 1'b0; end
                    2: boot_load = 1'b1;
                    3: begin status_rd = 1'b1; rd_issued = 1'b1; end
                    default: ;
                endcase
            end
            @(negedge clk);
            sw_trigger = 1'b0; wr_valid = 1'b0; boot_load = 1'b0; status_rd = 1'b0;
            k++;
            if (rd_issued) chk(prot_flag == 1'b1, "R10 read while busy", int'(prot_flag), 1);
        end
        chk(k == pred, {tag, " completion cycle (R8)"}, k, pred);
        for (int i = 0; i < NUM_CH; i++) begin
            e = (mode == 2'b00) ? start[i] : (mode == 2'b01) ? fld(nvm_code, i) : tgt[i];
            chk(code_of(i) == e, {tag, " final code"}, code_of(i), e);
            chk(dac_pd[i] == 1'b1, "R9 pd at done", int'(dac_pd[i]), 1);
            exp_code[i] = e; exp_pd[i] = 1'b1;
        end
        chk(prot_flag == 1'b1, "R10 flag at done", int'(prot_flag), 1);
        chk(wr_inhibit == 1'b0, "R7 inhibit released", int'(wr_inhibit), 0);
        @(negedge clk);
        chk(prot_done == 1'b0, "R9 done single pulse", int'(prot_done), 0);
        if (use_pin) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                chk(wr_inhibit == 1'b0, "R3 held pin no retrigger", int'(wr_inhibit), 0);
            end
            fault_pin = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) begin
            chk(code_of(i) == 0, "R1 reset code", code_of(i), 0);
            chk(dac_pd[i] == 1'b1, "R1 reset pd", int'(dac_pd[i]), 1);
        end
        chk(wr_inhibit == 1'b0 && prot_flag == 1'b0 && prot_done == 1'b0,
            "R1 reset flags", int'({wr_inhibit, prot_flag, prot_done}), 0);

        randomize_codes();
        do_boot();
        host_write(1, 12'h3A5, 1'b0);
        host_write(2, 12'h010, 1'b1);

        // Directed: immediate power-down via software bit.
        run_protect(2'b00, 1'b0, 1'b0);
        clear_flag();

        // Directed: trigger, host write and read in one cycle.
        do_boot();
        mode_sel = 2'b00;
        sw_trigger = 1'b1; status_rd = 1'b1;
        wr_valid = 1'b1; wr_chan = 2'd0; wr_code = CODE_W'(exp_code[0] ^ 12'hFFF); wr_pd = 1'b0;
        @(negedge clk);
        sw_trigger = 1'b0; status_rd = 1'b0; wr_valid = 1'b0;
        chk(prot_flag == 1'b1, "R10 trigger beats read", int'(prot_flag), 1);
        @(negedge clk);
        chk(prot_done == 1'b1, "R4 done after one edge", int'(prot_done), 1);
        chk(code_of(0) == exp_code[0], "R7 write on trigger cycle dropped", code_of(0), exp_code[0]);
        for (int i = 0; i < NUM_CH; i++) exp_pd[i] = 1'b1;
        @(negedge clk);
        clear_flag();

        // Directed: stored-code jump through the fault pin.
        randomize_codes();
        do_boot();
        host_write(3, 12'h7FF, 1'b0);
        run_protect(2'b01, 1'b1, 1'b0);
        clear_flag();

        // Directed slews: up, down, equal target, step dividing the distance.
        do_boot();
        for (int i = 0; i < NUM_CH; i++) begin
            margin_hi[i*CODE_W +: CODE_W] = CODE_W'(exp_code[i]);
        end
        margin_hi[0 +: CODE_W] = CODE_W'(exp_code[0] < 4000 ? exp_code[0] + 64 : exp_code[0] - 64);
        slew_step = 8'd16; slew_period = 8'd3;
        run_protect(2'b11, 1'b0, 1'b0);
        clear_flag();
        host_write(0, 4000, 1'b0);
        host_write(1, 100, 1'b0);
        host_write(2, 2000, 1'b0);
        host_write(3, 3000, 1'b0);
        margin_lo[0 +: CODE_W] = 12'd37;
        margin_lo[CODE_W +: CODE_W] = 12'd4095;
        margin_lo[2*CODE_W +: CODE_W] = 12'd2000;
        margin_lo[3*CODE_W +: CODE_W] = 12'd2999;
        slew_step = 8'd0; slew_period = 8'd0;
        slew_step = 8'd200;
        run_protect(2'b10, 1'b0, 1'b0);
        clear_flag();

        // Random responses with stimulus injected while busy.
        for (int t = 0; t < 40; t++) begin
            randomize_codes();
            slew_step = STEP_W'(8 + $urandom % 248);
            slew_period = DIV_W'($urandom % 5);
            if ($urandom % 2) do_boot();
            else host_write(int'($urandom % NUM_CH), int'($urandom % 4096), 1'b0);
            run_protect(2'($urandom), 1'($urandom), 1'b1);
            clear_flag();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule